// File: doc/BRIEF.md
# Cross-Thread Oldest/Youngest Selector

A reorder buffer shared by several hardware threads keeps a separate in-order queue for each thread. This block looks across those queues. It reports which thread holds the oldest head entry in the whole buffer, which thread holds the youngest tail entry, and whether any thread is able to retire this cycle. Retirement logic uses the oldest-head result to decide which thread commits next. Squash recovery uses the youngest-tail result to move the global tail.

Each thread supplies five things: an active bit, a non-empty bit, the sequence number of its head entry, a head-ready bit and the sequence number of its tail entry. A thread takes part in the selection only when it is both active and non-empty. Within that set, the head is the thread with the smallest head sequence number and the tail is the thread with the largest tail sequence number. On a tie the lower thread index wins. The results are registered, so they follow the inputs with one clock of latency.

The selection is recomputed on every clock. This covers both cases that change it: a retirement that moves a thread's head, and a squash that removes a thread's youngest entry. A parameter chooses between two comparator structures that give the same results: a linear scan and a balanced tree.

Top module: `rob_age_select`

## Requirements
- R1: While `rst_n` is low, every output is 0: both valid flags, both thread indices and `commit_ok`.
- R2: A thread is qualifying only when its `thr_active` bit and its `thr_nonempty` bit are both 1. The sequence numbers of a non-qualifying thread have no effect on any output.
- R3: When `oldest_vld` is 1, `oldest_tid` is the qualifying thread whose head sequence number (bits `[i*SEQ_W +: SEQ_W]` of `thr_head_seq` for thread i) is smallest.
- R4: When `youngest_vld` is 1, `youngest_tid` is the qualifying thread whose tail sequence number (bits `[i*SEQ_W +: SEQ_W]` of `thr_tail_seq`) is largest.
- R5: When several qualifying threads share the winning sequence number, the lowest thread index is selected. This applies to both the head and the tail selection.
- R6: When no thread qualifies, `oldest_vld`, `youngest_vld`, `oldest_tid`, `youngest_tid` and `commit_ok` are all 0. When at least one thread qualifies, both valid flags are 1.
- R7: `commit_ok` is 1 exactly when at least one qualifying thread has its `thr_head_ready` bit set. A ready bit on an inactive or empty thread has no effect.
- R8: Every output shows the value computed from the inputs sampled at the previous rising clock edge. Changing the inputs leaves the outputs unchanged until that edge.
- R9: Sequence numbers are compared as plain unsigned integers over their full range, including 0 and the all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_active | input | NUM_THREADS | Per-thread active bit |
| thr_nonempty | input | NUM_THREADS | Per-thread queue non-empty bit |
| thr_head_ready | input | NUM_THREADS | Per-thread head entry ready to retire |
| thr_head_seq | input | NUM_THREADS*SEQ_W | Head sequence numbers, thread i at `[i*SEQ_W +: SEQ_W]` |
| thr_tail_seq | input | NUM_THREADS*SEQ_W | Tail sequence numbers, thread i at `[i*SEQ_W +: SEQ_W]` |
| oldest_tid | output | TID_W | Thread holding the globally oldest head |
| oldest_vld | output | 1 | `oldest_tid` is meaningful |
| youngest_tid | output | TID_W | Thread holding the globally youngest tail |
| youngest_vld | output | 1 | `youngest_tid` is meaningful |
| commit_ok | output | 1 | Some qualifying thread can retire |

## Verification
The bench targets the cases where a careless selector picks the wrong thread:

- **Inactive or empty threads carrying extreme values.** Inactive threads and empty threads are given very small head numbers, very large tail numbers and set ready bits. A design that ignored either qualification bit would choose one of them or raise `commit_ok` falsely.
- **Ties.** Equal head numbers and equal tail numbers appear across threads. A design using a non-strict compare would report the higher index instead.
- **No qualifying thread.** Vectors with no active thread, and with every thread empty, catch a design that leaves stale or non-zero indices.
- **Full-range values and timing.** Values of 0 and all-ones check the comparison at its extremes. A directed step checks that the outputs hold until the clock edge, then checks that reset clears them at once.

// File: rtl/rob_age_pkg.sv
package rob_age_pkg;

   typedef enum logic {
      SEL_CHAIN = 1'b0,
      SEL_TREE  = 1'b1
   } sel_arch_e;

   // True when candidate a strictly beats b: smaller for the oldest-head
   // search, larger for the youngest-tail search.
   function automatic logic seq_beats(input logic [63:0] a,
                                      input logic [63:0] b,
                                      input logic        want_max);
      if (want_max) return a > b;
      else          return a < b;
   endfunction

endpackage

// File: rtl/rob_age_qualify.sv
module rob_age_qualify #(
   parameter int NUM_THREADS = 4
) (
   input  logic [NUM_THREADS-1:0] active,
   input  logic [NUM_THREADS-1:0] nonempty,
   input  logic [NUM_THREADS-1:0] head_ready,
   output logic [NUM_THREADS-1:0] qual,
   output logic                   any_qual,
   output logic                   any_ready
);

   assign qual      = active & nonempty;
   assign any_qual  = |qual;
   assign any_ready = |(qual & head_ready);

endmodule

// File: rtl/rob_age_pick.sv
module rob_age_pick
   import rob_age_pkg::*;
#(
   parameter int        NUM_THREADS = 4,
   parameter int        SEQ_W       = 16,
   parameter bit        WANT_MAX    = 1'b0,
   parameter sel_arch_e ARCH        = SEL_TREE,
   localparam int       TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
   input  logic [NUM_THREADS-1:0]       qual,
   input  logic [NUM_THREADS*SEQ_W-1:0] seq_flat,
   output logic                         pick_vld,
   output logic [TID_W-1:0]             pick_idx
);

   if (SEQ_W > 64) begin : g_bad_width
      $error("rob_age_pick: SEQ_W above 64 not supported");
   end

   if (ARCH == SEL_CHAIN) begin : g_chain
      // Linear scan: the first qualifying thread is taken as is, later ones
      // replace it only when strictly better (keeps lower index on ties).
      logic [NUM_THREADS:0] c_vld;
      logic [TID_W-1:0]     c_idx [NUM_THREADS+1];
      logic [SEQ_W-1:0]     c_seq [NUM_THREADS+1];

      assign c_vld[0] = 1'b0;
      assign c_idx[0] = '0;
      assign c_seq[0] = '0;

      for (genvar i = 0; i < NUM_THREADS; i++) begin : g_stage
         logic [SEQ_W-1:0] s_i;
         logic             take;
         assign s_i  = seq_flat[i*SEQ_W +: SEQ_W];
         assign take = qual[i] &&
                       (!c_vld[i] ||
                        seq_beats(64'(s_i), 64'(c_seq[i]), WANT_MAX));
         assign c_vld[i+1] = c_vld[i] | qual[i];
         assign c_idx[i+1] = take ? TID_W'(i) : c_idx[i];
         assign c_seq[i+1] = take ? s_i       : c_seq[i];
      end

      assign pick_vld = c_vld[NUM_THREADS];
      assign pick_idx = c_vld[NUM_THREADS] ? c_idx[NUM_THREADS] : '0;

   end else begin : g_tree
      // Balanced tree in heap order; leaves padded to a power of two with
      // invalid entries. Left subtree holds lower indices, so the right
      // child wins only when strictly better.
      localparam int LVLS   = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1;
      localparam int LEAVES = 1 << LVLS;
      localparam int NODES  = 2 * LEAVES - 1;

      logic [NODES-1:0] n_vld;
      logic [TID_W-1:0] n_idx [NODES];
      logic [SEQ_W-1:0] n_seq [NODES];

      for (genvar l = 0; l < LEAVES; l++) begin : g_leaf
         if (l < NUM_THREADS) begin : g_real
            assign n_vld[LEAVES-1+l] = qual[l];
            assign n_idx[LEAVES-1+l] = TID_W'(l);
            assign n_seq[LEAVES-1+l] = seq_flat[l*SEQ_W +: SEQ_W];
         end else begin : g_pad
            assign n_vld[LEAVES-1+l] = 1'b0;
            assign n_idx[LEAVES-1+l] = '0;
            assign n_seq[LEAVES-1+l] = '0;
         end
      end

      for (genvar n = 0; n < LEAVES - 1; n++) begin : g_node
         logic go_right;
         assign go_right = n_vld[2*n+2] &&
                           (!n_vld[2*n+1] ||
                            seq_beats(64'(n_seq[2*n+2]), 64'(n_seq[2*n+1]),
                                      WANT_MAX));
         assign n_vld[n] = n_vld[2*n+1] | n_vld[2*n+2];
         assign n_idx[n] = go_right ? n_idx[2*n+2] : n_idx[2*n+1];
         assign n_seq[n] = go_right ? n_seq[2*n+2] : n_seq[2*n+1];
      end

      assign pick_vld = n_vld[0];
      assign pick_idx = n_vld[0] ? n_idx[0] : '0;
   end

endmodule

// File: rtl/rob_age_select.sv
module rob_age_select
   import rob_age_pkg::*;
#(
   parameter int        NUM_THREADS = 4,
   parameter int        SEQ_W       = 16,
   parameter sel_arch_e ARCH        = SEL_TREE,
   localparam int       TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_THREADS-1:0]       thr_active,
   input  logic [NUM_THREADS-1:0]       thr_nonempty,
   input  logic [NUM_THREADS-1:0]       thr_head_ready,
   input  logic [NUM_THREADS*SEQ_W-1:0] thr_head_seq,
   input  logic [NUM_THREADS*SEQ_W-1:0] thr_tail_seq,
   output logic [TID_W-1:0]             oldest_tid,
   output logic                         oldest_vld,
   output logic [TID_W-1:0]             youngest_tid,
   output logic                         youngest_vld,
   output logic                         commit_ok
);

   if (NUM_THREADS < 2) begin : g_bad_threads
      $error("rob_age_select: NUM_THREADS must be at least 2");
   end
   if (SEQ_W < 1) begin : g_bad_seq
      $error("rob_age_select: SEQ_W must be positive");
   end

   logic [NUM_THREADS-1:0] qual;
   logic                   any_qual;
   logic                   any_ready;
   logic                   old_vld_d, yng_vld_d;
   logic [TID_W-1:0]       old_idx_d, yng_idx_d;

   rob_age_qualify #(.NUM_THREADS(NUM_THREADS)) u_qualify (
      .active     (thr_active),
      .nonempty   (thr_nonempty),
      .head_ready (thr_head_ready),
      .qual       (qual),
      .any_qual   (any_qual),
      .any_ready  (any_ready)
   );

   rob_age_pick #(
      .NUM_THREADS (NUM_THREADS),
      .SEQ_W       (SEQ_W),
      .WANT_MAX    (1'b0),
      .ARCH        (ARCH)
   ) u_pick_head (
      .qual     (qual),
      .seq_flat (thr_head_seq),
      .pick_vld (old_vld_d),
      .pick_idx (old_idx_d)
   );

   rob_age_pick #(
      .NUM_THREADS (NUM_THREADS),
      .SEQ_W       (SEQ_W),
      .WANT_MAX    (1'b1),
      .ARCH        (ARCH)
   ) u_pick_tail (
      .qual     (qual),
      .seq_flat (thr_tail_seq),
      .pick_vld (yng_vld_d),
      .pick_idx (yng_idx_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oldest_tid   <= '0;
         oldest_vld   <= 1'b0;
         youngest_tid <= '0;
         youngest_vld <= 1'b0;
         commit_ok    <= 1'b0;
      end else begin
         oldest_tid   <= old_idx_d;
         oldest_vld   <= old_vld_d & any_qual;
         youngest_tid <= yng_idx_d;
         youngest_vld <= yng_vld_d & any_qual;
         commit_ok    <= any_ready;
      end
   end

endmodule

// File: rtl/rob_age_select_chk.sv
module rob_age_select_chk #(
   parameter int  NUM_THREADS = 4,
   localparam int TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NUM_THREADS-1:0] thr_active,
   input logic [NUM_THREADS-1:0] thr_nonempty,
   input logic [NUM_THREADS-1:0] thr_head_ready,
   input logic [TID_W-1:0]       oldest_tid,
   input logic                   oldest_vld,
   input logic [TID_W-1:0]       youngest_tid,
   input logic                   youngest_vld,
   input logic                   commit_ok
);

   logic                   armed;
   logic [NUM_THREADS-1:0] elig_q;
   logic [NUM_THREADS-1:0] rdy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed  <= 1'b0;
         elig_q <= '0;
         rdy_q  <= '0;
      end else begin
         armed  <= 1'b1;
         elig_q <= thr_active & thr_nonempty;
         rdy_q  <= thr_head_ready;
      end
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (!oldest_vld && !youngest_vld && !commit_ok &&
                  oldest_tid == '0 && youngest_tid == '0) || !rst_n);

   // R6
   valid_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (oldest_vld == (|elig_q)) && (youngest_vld == (|elig_q)));

   // R2
   head_pick_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && oldest_vld) |-> elig_q[oldest_tid]);

   // R2
   tail_pick_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && youngest_vld) |-> elig_q[youngest_tid]);

   // R7
   commit_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (commit_ok == (|(elig_q & rdy_q))));

   // R6
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !oldest_vld |-> (!commit_ok && oldest_tid == '0 && youngest_tid == '0));

endmodule

bind rob_age_select rob_age_select_chk #(.NUM_THREADS(NUM_THREADS)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .thr_active     (thr_active),
   .thr_nonempty   (thr_nonempty),
   .thr_head_ready (thr_head_ready),
   .oldest_tid     (oldest_tid),
   .oldest_vld     (oldest_vld),
   .youngest_tid   (youngest_tid),
   .youngest_vld   (youngest_vld),
   .commit_ok      (commit_ok)
);

// File: tb/rob_age_select_bench.sv
module rob_age_select_bench;

   localparam int NT    = 4;
   localparam int SW    = 16;
   localparam int TW    = 2;
   localparam int NV    = 9;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NT-1:0]    act = '0, nem = '0, rdy = '0;
   logic [NT*SW-1:0] hseq = '0, tseq = '0;
   logic [TW-1:0]    o_tid, y_tid;
   logic             o_vld, y_vld, c_ok;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   rob_age_select #(.NUM_THREADS(NT), .SEQ_W(SW)) u_rob_age_select (
      .clk            (clk),
      .rst_n          (rst_n),
      .thr_active     (act),
      .thr_nonempty   (nem),
      .thr_head_ready (rdy),
      .thr_head_seq   (hseq),
      .thr_tail_seq   (tseq),
      .oldest_tid     (o_tid),
      .oldest_vld     (o_vld),
      .youngest_tid   (y_tid),
      .youngest_vld   (y_vld),
      .commit_ok      (c_ok)
   );

   // Sequence words are {thread3, thread2, thread1, thread0}.
   localparam logic [NT-1:0]    V_ACT [NV] = '{4'hF, 4'hB, 4'hF, 4'hF, 4'h0, 4'hF, 4'h8, 4'hA, 4'h3};
   localparam logic [NT-1:0]    V_NEM [NV] = '{4'hF, 4'hF, 4'hE, 4'hF, 4'hF, 4'h0, 4'hF, 4'hF, 4'h3};
   localparam logic [NT-1:0]    V_RDY [NV] = '{4'h0, 4'h4, 4'h1, 4'h8, 4'hF, 4'hF, 4'h8, 4'h2, 4'h0};
   localparam logic [NT*SW-1:0] V_HS  [NV] = '{
      {16'd30, 16'd5,  16'd20, 16'd10},
      {16'd30, 16'd5,  16'd20, 16'd10},
      {16'd30, 16'd50, 16'd20, 16'd1},
      {16'd7,  16'd7,  16'd7,  16'd7},
      {16'd4,  16'd3,  16'd2,  16'd1},
      {16'd4,  16'd3,  16'd2,  16'd1},
      {16'd100,16'd1,  16'd1,  16'd1},
      {16'd4,  16'd0,  16'd4,  16'd0},
      {16'd5,  16'd5,  16'd0,  16'hFFFF}};
   localparam logic [NT*SW-1:0] V_TS  [NV] = '{
      {16'd40, 16'd8,  16'd25, 16'd15},
      {16'd40, 16'd8,  16'd25, 16'd15},
      {16'd40, 16'd60, 16'd25, 16'd99},
      {16'd3,  16'd12, 16'd12, 16'd9},
      {16'd9,  16'd9,  16'd9,  16'd9},
      {16'd9,  16'd9,  16'd9,  16'd9},
      {16'd200,16'd900,16'd900,16'd900},
      {16'd51, 16'd999,16'd50, 16'd999},
      {16'd5,  16'd5,  16'd0,  16'hFFFF}};
   localparam logic          E_OV [NV] = '{1,1,1,1,0,0,1,1,1};
   localparam logic [TW-1:0] E_OT [NV] = '{2,0,1,0,0,0,3,1,1};
   localparam logic          E_YV [NV] = '{1,1,1,1,0,0,1,1,1};
   localparam logic [TW-1:0] E_YT [NV] = '{3,3,2,1,0,0,3,3,0};
   localparam logic          E_CM [NV] = '{0,0,0,1,0,0,1,1,0};
   localparam string         V_REQ [NV] = '{"R3 R4", "R2 R7", "R2 R7", "R5 R7",
                                            "R6", "R6", "R2 R7", "R5 R2", "R9"};

   task automatic cmp(input string req, input string what, input int act_v, input int exp_v);
      checks++;
      if (act_v != exp_v) begin
         fails++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act_v, exp_v);
      end
   endtask

   task automatic cmp_all(input string req, input logic ov, input logic [TW-1:0] ot,
                          input logic yv, input logic [TW-1:0] yt, input logic cm);
      cmp(req, "oldest_vld",   int'(o_vld), int'(ov));
      cmp(req, "oldest_tid",   int'(o_tid), int'(ot));
      cmp(req, "youngest_vld", int'(y_vld), int'(yv));
      cmp(req, "youngest_tid", int'(y_tid), int'(yt));
      cmp(req, "commit_ok",    int'(c_ok),  int'(cm));
   endtask

   task automatic drive(input int k);
      act  = V_ACT[k];
      nem  = V_NEM[k];
      rdy  = V_RDY[k];
      hseq = V_HS[k];
      tseq = V_TS[k];
   endtask

   initial begin
      // R1: outputs clear under reset even with qualifying inputs present
      drive(3);
      repeat (3) @(negedge clk);
      cmp_all("R1", 0, 0, 0, 0, 0);
      rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         @(negedge clk);
         drive(k);
         @(negedge clk);
         cmp_all(V_REQ[k], E_OV[k], E_OT[k], E_YV[k], E_YT[k], E_CM[k]);
      end

      // R8: new inputs do not show before the next rising edge
      @(negedge clk);
      drive(0);
      #2;
      cmp_all("R8 hold", E_OV[NV-1], E_OT[NV-1], E_YV[NV-1], E_YT[NV-1], E_CM[NV-1]);
      @(negedge clk);
      cmp_all("R8 update", E_OV[0], E_OT[0], E_YV[0], E_YT[0], E_CM[0]);

      // R1: asynchronous reset mid-run clears outputs at once
      rst_n = 1'b0;
      #2;
      cmp_all("R1 async", 0, 0, 0, 0, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cmp_all("R1 release", E_OV[0], E_OT[0], E_YV[0], E_YT[0], E_CM[0]);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

endmodule